// File: doc/BRIEF.md
# Ethernet Transmit Error-Stop Controller

This block watches over the transmit enable of a CSMA/CD transmitter while it sends one frame after another. The MAC reports how each attempt ends through single-cycle outcome events: a normal collision, a late collision, lost carrier, a data underrun, a failed SQE test, or success. Two configuration inputs decide whether lost carrier and a failed SQE test are treated as fatal.

For each frame the block counts collisions. A collision below the attempt limit asks the backoff timer to start and tells the DMA side to feed the frame again. It does this whether or not the collision fell in the preamble. A fatal outcome drops the transmit enable, latches a one-hot error code and raises a one-cycle interrupt. Software resumes by pulsing the enable-set input, which also clears the latched code. After a successful frame the enable stays high and the next frame proceeds.

All outputs are registered. An event presented in one cycle shows on the outputs after the next rising clock edge.

Top module: `txstop_ctrl`

## Requirements
- R1: After reset, `tx_en`, `err_status`, `col_count`, `err_irq`, `backoff_req` and `dma_restart` are all zero.
- R2: While `tx_en` is low, a pulse on `sw_enable_set` sets `tx_en` and clears `err_status` and `col_count`. While `tx_en` is low, outcome events do not change `tx_en`, `err_status` or `col_count`, and they raise no pulse.
- R3: A late collision while enabled clears `tx_en` and sets `err_status` to 5'b00010 (bit 1).
- R4: An underrun while enabled clears `tx_en` and sets `err_status` to 5'b01000 (bit 3).
- R5: Lost carrier clears `tx_en` and sets `err_status` to 5'b00100 (bit 2) only when `cfg_mon_carrier` is 1. Otherwise it has no effect.
- R6: A failed SQE test clears `tx_en` and sets `err_status` to 5'b10000 (bit 4) only when `cfg_stop_sqe` is 1. Otherwise it has no effect.
- R7: A collision that is not the MAX_ATTEMPTS-th of the frame increments `col_count`. It pulses `backoff_req` and `dma_restart` for one cycle, and `tx_en` stays high.
- R8: The MAX_ATTEMPTS-th (default 16) collision of one frame is fatal. It clears `tx_en`, sets `err_status` to 5'b00001 (bit 0), and gives no backoff or restart pulse.
- R9: A success event without a collision keeps `tx_en` high and returns `col_count` to 0. A `frame_start` pulse also returns `col_count` to 0.
- R10: Fatal outcomes take priority over the collision restart. Among fatal outcomes in the same cycle, the order is underrun, then late collision, then excess collisions, then lost carrier, then SQE.
- R11: Each fatal outcome gives exactly one single-cycle `err_irq` pulse, and `err_status` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mon_carrier | input | 1 | Treat lost carrier as fatal |
| cfg_stop_sqe | input | 1 | Treat a failed SQE test as fatal |
| sw_enable_set | input | 1 | Software pulse that sets transmit enable |
| frame_start | input | 1 | A new frame begins; clears the collision count |
| ev_collision | input | 1 | Normal collision on the current attempt |
| ev_late_col | input | 1 | Late collision |
| ev_carrier_lost | input | 1 | Carrier sense lost during transmission |
| ev_underrun | input | 1 | Transmit data underrun |
| ev_sqe_fail | input | 1 | SQE test failed |
| ev_success | input | 1 | Frame sent successfully |
| tx_en | output | 1 | Transmit enable |
| err_status | output | 5 | Latched one-hot fatal error code |
| err_irq | output | 1 | One-cycle pulse on a fatal error |
| backoff_req | output | 1 | One-cycle request to start backoff |
| dma_restart | output | 1 | One-cycle request to refeed the frame |
| col_count | output | 5 | Collisions counted on the current frame |

## Verification
The bench drives fifteen collisions and then a sixteenth on the same frame. A design with an off-by-one limit would stop one attempt early, or would still restart on the sixteenth. It applies lost carrier and SQE failures with each configuration bit set and clear, so a missing gate shows up either as a stray stop or as a missed one. It presents several outcomes in one cycle to expose a wrong priority, such as a restart pulse beside a fatal error, or a two-hot or wrongly chosen error code. It also feeds events while the transmitter is disabled, where a design that does not gate them would latch codes or count collisions.

// File: rtl/txstop_pkg.sv
package txstop_pkg;
    localparam int ERR_W = 5;

    // bit positions of the latched error code
    localparam int ERR_EXCESS   = 0;
    localparam int ERR_LATE     = 1;
    localparam int ERR_CARRIER  = 2;
    localparam int ERR_UNDERRUN = 3;
    localparam int ERR_SQE      = 4;

    // priority slots, slot 0 wins
    localparam int PRI_UNDERRUN = 0;
    localparam int PRI_LATE     = 1;
    localparam int PRI_EXCESS   = 2;
    localparam int PRI_CARRIER  = 3;
    localparam int PRI_SQE      = 4;

    typedef struct packed {
        logic             tx_en;
        logic [ERR_W-1:0] err_status;
        logic             irq;
        logic             backoff;
        logic             restart;
    } ctrl_state_t;
endpackage

// File: rtl/txstop_prio_pick.sv
module txstop_prio_pick #(
    parameter int N = 5
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    for (genvar i = 0; i < N; i++) begin : g_slot
        if (i == 0) begin : g_first
            assign grant[i] = req[i];
        end else begin : g_rest
            assign grant[i] = req[i] & ~(|req[i-1:0]);
        end
    end
    assign any = |req;
endmodule

// File: rtl/txstop_retry_cnt.sv
module txstop_retry_cnt #(
    parameter int MAX_ATTEMPTS = 16,
    parameter int CNT_W        = $clog2(MAX_ATTEMPTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             incr,
    output logic [CNT_W-1:0] count,
    output logic             at_last
);
    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(MAX_ATTEMPTS - 1);
    localparam logic [CNT_W-1:0] TOP_V  = CNT_W'(MAX_ATTEMPTS);

    logic [CNT_W-1:0] cnt_q, cnt_d, base;

    always_comb begin
        base  = clear ? '0 : cnt_q;
        cnt_d = base;
        if (incr && base != TOP_V) begin
            cnt_d = base + 1'b1;
        end
    end

    assign at_last = (base == LAST_V);
    assign count   = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/txstop_ctrl.sv
module txstop_ctrl
    import txstop_pkg::*;
#(
    parameter int MAX_ATTEMPTS = 16,
    parameter int CNT_W        = $clog2(MAX_ATTEMPTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_mon_carrier,
    input  logic             cfg_stop_sqe,
    input  logic             sw_enable_set,
    input  logic             frame_start,
    input  logic             ev_collision,
    input  logic             ev_late_col,
    input  logic             ev_carrier_lost,
    input  logic             ev_underrun,
    input  logic             ev_sqe_fail,
    input  logic             ev_success,
    output logic             tx_en,
    output logic [ERR_W-1:0] err_status,
    output logic             err_irq,
    output logic             backoff_req,
    output logic             dma_restart,
    output logic [CNT_W-1:0] col_count
);
    ctrl_state_t st_q, st_d;

    logic             active;
    logic             cnt_clear, cnt_incr, cnt_last;
    logic [ERR_W-1:0] pri_req, pri_grant;
    logic             fatal;
    logic [ERR_W-1:0] code;

    assign active    = st_q.tx_en;
    assign cnt_incr  = active & ev_collision;
    assign cnt_clear = frame_start | (sw_enable_set & ~active)
                     | (active & ev_success & ~ev_collision);

    txstop_retry_cnt #(
        .MAX_ATTEMPTS(MAX_ATTEMPTS),
        .CNT_W       (CNT_W)
    ) retry_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (cnt_clear),
        .incr   (cnt_incr),
        .count  (col_count),
        .at_last(cnt_last)
    );

    always_comb begin
        pri_req               = '0;
        pri_req[PRI_UNDERRUN] = active & ev_underrun;
        pri_req[PRI_LATE]     = active & ev_late_col;
        pri_req[PRI_EXCESS]   = active & ev_collision & cnt_last;
        pri_req[PRI_CARRIER]  = active & ev_carrier_lost & cfg_mon_carrier;
        pri_req[PRI_SQE]      = active & ev_sqe_fail & cfg_stop_sqe;
    end

    txstop_prio_pick #(.N(ERR_W)) pick_i (
        .req  (pri_req),
        .grant(pri_grant),
        .any  (fatal)
    );

    always_comb begin
        code               = '0;
        code[ERR_UNDERRUN] = pri_grant[PRI_UNDERRUN];
        code[ERR_LATE]     = pri_grant[PRI_LATE];
        code[ERR_EXCESS]   = pri_grant[PRI_EXCESS];
        code[ERR_CARRIER]  = pri_grant[PRI_CARRIER];
        code[ERR_SQE]      = pri_grant[PRI_SQE];
    end

    always_comb begin
        st_d         = st_q;
        st_d.irq     = 1'b0;
        st_d.backoff = 1'b0;
        st_d.restart = 1'b0;
        if (sw_enable_set && !active) begin
            st_d.tx_en      = 1'b1;
            st_d.err_status = '0;
        end
        if (fatal) begin
            st_d.tx_en      = 1'b0;
            st_d.err_status = code;
            st_d.irq        = 1'b1;
        end else if (cnt_incr) begin
            st_d.backoff = 1'b1;
            st_d.restart = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_en       = st_q.tx_en;
    assign err_status  = st_q.err_status;
    assign err_irq     = st_q.irq;
    assign backoff_req = st_q.backoff;
    assign dma_restart = st_q.restart;
endmodule

// File: rtl/txstop_ctrl_chk.sv
module txstop_ctrl_chk #(
    parameter int MAX_ATTEMPTS = 16,
    parameter int CNT_W        = $clog2(MAX_ATTEMPTS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_mon_carrier,
    input logic             cfg_stop_sqe,
    input logic             sw_enable_set,
    input logic             frame_start,
    input logic             ev_collision,
    input logic             ev_late_col,
    input logic             ev_carrier_lost,
    input logic             ev_underrun,
    input logic             ev_sqe_fail,
    input logic             ev_success,
    input logic             tx_en,
    input logic [4:0]       err_status,
    input logic             err_irq,
    input logic             backoff_req,
    input logic             dma_restart,
    input logic [CNT_W-1:0] col_count
);
    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(MAX_ATTEMPTS - 1);

    logic fatal_ev;
    assign fatal_ev = ev_late_col | ev_underrun | (cfg_mon_carrier & ev_carrier_lost)
                    | (cfg_stop_sqe & ev_sqe_fail);

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !sw_enable_set) |=> (!tx_en && !err_irq && !backoff_req && !dma_restart));

    a_r2_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && sw_enable_set) |=> (tx_en && err_status == 5'b0));

    a_r3_late_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && ev_late_col) |=> (!tx_en && err_irq));

    a_r4_underrun_code: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && ev_underrun) |=> (!tx_en && err_status == 5'b01000));

    a_r5_carrier_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !fatal_ev && !ev_collision) |=> tx_en);

    a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && ev_collision && !fatal_ev && !frame_start && col_count < LAST_V)
        |=> (backoff_req && dma_restart && tx_en && col_count == $past(col_count) + 1'b1));

    a_r9_success_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && ev_success && !ev_collision && !fatal_ev) |=> (tx_en && col_count == '0));

    a_r10_no_restart_on_fatal: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> (!dma_restart && !backoff_req && !tx_en));

    a_r11_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |=> !err_irq);

    a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(err_status));
endmodule

bind txstop_ctrl txstop_ctrl_chk #(
    .MAX_ATTEMPTS(MAX_ATTEMPTS),
    .CNT_W       (CNT_W)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_mon_carrier(cfg_mon_carrier),
    .cfg_stop_sqe   (cfg_stop_sqe),
    .sw_enable_set  (sw_enable_set),
    .frame_start    (frame_start),
    .ev_collision   (ev_collision),
    .ev_late_col    (ev_late_col),
    .ev_carrier_lost(ev_carrier_lost),
    .ev_underrun    (ev_underrun),
    .ev_sqe_fail    (ev_sqe_fail),
    .ev_success     (ev_success),
    .tx_en          (tx_en),
    .err_status     (err_status),
    .err_irq        (err_irq),
    .backoff_req    (backoff_req),
    .dma_restart    (dma_restart),
    .col_count      (col_count)
);

// File: tb/txstop_ctrl_tb_top.sv
module txstop_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_mon_carrier = 1'b0, cfg_stop_sqe = 1'b0;
    logic       sw_enable_set = 1'b0, frame_start = 1'b0;
    logic       ev_collision = 1'b0, ev_late_col = 1'b0, ev_carrier_lost = 1'b0;
    logic       ev_underrun = 1'b0, ev_sqe_fail = 1'b0, ev_success = 1'b0;
    logic       tx_en, err_irq, backoff_req, dma_restart;
    logic [4:0] err_status, col_count;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    always #2 clk = ~clk;

    txstop_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_mon_carrier(cfg_mon_carrier), .cfg_stop_sqe(cfg_stop_sqe),
        .sw_enable_set(sw_enable_set), .frame_start(frame_start),
        .ev_collision(ev_collision), .ev_late_col(ev_late_col),
        .ev_carrier_lost(ev_carrier_lost), .ev_underrun(ev_underrun),
        .ev_sqe_fail(ev_sqe_fail), .ev_success(ev_success),
        .tx_en(tx_en), .err_status(err_status), .err_irq(err_irq),
        .backoff_req(backoff_req), .dma_restart(dma_restart), .col_count(col_count)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive one cycle of inputs from a negedge, return at the next negedge
    task automatic step(input bit set, input bit fs, input bit col, input bit late,
                        input bit car, input bit und, input bit sqe, input bit suc);
        sw_enable_set = set; frame_start = fs; ev_collision = col; ev_late_col = late;
        ev_carrier_lost = car; ev_underrun = und; ev_sqe_fail = sqe; ev_success = suc;
        @(negedge clk);
        sw_enable_set = 0; frame_start = 0; ev_collision = 0; ev_late_col = 0;
        ev_carrier_lost = 0; ev_underrun = 0; ev_sqe_fail = 0; ev_success = 0;
    endtask

    task automatic enable();
        step(1, 1, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_reset();
        check("R1 tx_en", tx_en, 0);
        check("R1 err_status", err_status, 0);
        check("R1 col_count", col_count, 0);
        check("R1 pulses", {err_irq, backoff_req, dma_restart}, 0);
    endtask

    task automatic t_disabled_ignore();
        step(0, 0, 1, 1, 0, 1, 0, 0);
        check("R2 ignored tx_en", tx_en, 0);
        check("R2 ignored status", err_status, 0);
        check("R2 ignored count", col_count, 0);
        check("R2 ignored pulses", {err_irq, backoff_req, dma_restart}, 0);
        enable();
        check("R2 enable set", tx_en, 1);
    endtask

    task automatic t_late();
        step(0, 0, 0, 1, 0, 0, 0, 0);
        check("R3 late tx_en", tx_en, 0);
        check("R3 late code", err_status, 5'b00010);
        check("R11 irq raised", err_irq, 1);
        @(negedge clk);
        check("R11 irq single", err_irq, 0);
        enable();
        check("R2 status cleared", err_status, 0);
        check("R2 re-enabled", tx_en, 1);
    endtask

    task automatic t_underrun();
        step(0, 0, 0, 0, 0, 1, 0, 0);
        check("R4 underrun tx_en", tx_en, 0);
        check("R4 underrun code", err_status, 5'b01000);
        enable();
    endtask

    task automatic t_carrier();
        cfg_mon_carrier = 0;
        step(0, 0, 0, 0, 1, 0, 0, 0);
        check("R5 carrier ungated tx_en", tx_en, 1);
        check("R5 carrier ungated status", err_status, 0);
        cfg_mon_carrier = 1;
        step(0, 0, 0, 0, 1, 0, 0, 0);
        check("R5 carrier gated tx_en", tx_en, 0);
        check("R5 carrier code", err_status, 5'b00100);
        cfg_mon_carrier = 0;
        enable();
    endtask

    task automatic t_sqe();
        cfg_stop_sqe = 0;
        step(0, 0, 0, 0, 0, 0, 1, 0);
        check("R6 sqe ungated tx_en", tx_en, 1);
        check("R6 sqe ungated irq", err_irq, 0);
        cfg_stop_sqe = 1;
        step(0, 0, 0, 0, 0, 0, 1, 0);
        check("R6 sqe tx_en", tx_en, 0);
        check("R6 sqe code", err_status, 5'b10000);
        cfg_stop_sqe = 0;
        enable();
    endtask

    task automatic t_collisions();
        step(0, 1, 0, 0, 0, 0, 0, 0);
        for (int i = 1; i <= 15; i++) begin
            step(0, 0, 1, 0, 0, 0, 0, 0);
            check("R7 count", col_count, i);
            check("R7 restart pulses", {backoff_req, dma_restart, tx_en}, 3'b111);
        end
        @(negedge clk);
        check("R7 pulse one cycle", {backoff_req, dma_restart}, 0);
        step(0, 0, 1, 0, 0, 0, 0, 0);
        check("R8 excess tx_en", tx_en, 0);
        check("R8 excess code", err_status, 5'b00001);
        check("R8 no restart", {backoff_req, dma_restart}, 0);
        enable();
    endtask

    task automatic t_success();
        step(0, 0, 1, 0, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0, 0, 0);
        check("R9 count before", col_count, 2);
        step(0, 0, 0, 0, 0, 0, 0, 1);
        check("R9 success count", col_count, 0);
        check("R9 success tx_en", tx_en, 1);
        step(0, 0, 1, 0, 0, 0, 0, 0);
        step(0, 1, 0, 0, 0, 0, 0, 0);
        check("R9 frame_start count", col_count, 0);
    endtask

    task automatic t_priority();
        step(0, 0, 1, 1, 0, 0, 0, 0);
        check("R10 fatal over collision code", err_status, 5'b00010);
        check("R10 no restart", {backoff_req, dma_restart}, 0);
        enable();
        cfg_mon_carrier = 1; cfg_stop_sqe = 1;
        step(0, 0, 0, 1, 1, 1, 1, 0);
        check("R10 underrun wins", err_status, 5'b01000);
        enable();
        step(0, 0, 0, 1, 1, 0, 1, 0);
        check("R10 late over carrier", err_status, 5'b00010);
        enable();
        step(0, 0, 0, 0, 1, 0, 1, 0);
        check("R10 carrier over sqe", err_status, 5'b00100);
        cfg_mon_carrier = 0; cfg_stop_sqe = 0;
        enable();
        for (int i = 0; i < 15; i++) step(0, 0, 1, 0, 0, 0, 0, 0);
        cfg_mon_carrier = 1;
        step(0, 0, 1, 0, 1, 0, 0, 0);
        check("R10 excess over carrier", err_status, 5'b00001);
        cfg_mon_carrier = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled_ignore();
        t_late();
        t_underrun();
        t_carrier();
        t_sqe();
        t_collisions();
        t_success();
        t_priority();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 20000);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule